// File: doc/BRIEF.md
# Threshold-Driven FIFO DMA Requester

This block is a circular data buffer of 32 words, each 16 bits wide. It sits between a 16-bit register port on the host side and a byte engine on the card side. A direction input chooses how data moves. In receive direction the card side fills the buffer and the host drains it. In transmit direction the host fills it and the card side drains it. Two programmable watermarks govern the buffer: a high level used while receiving and a low level used while transmitting.

When the fill count crosses a watermark, the block reports it in one of two ways. If DMA is enabled for that direction, it raises a DMA request line. If not, it raises a polled flag that software reads. Both kinds of indication are gated by the direction. Both are also suppressed while the buffer is idle, meaning no transfer is active and the buffer is empty.

The watermarks and the two DMA enables are loaded together through a single configuration strobe. Reading from the host side when the buffer is empty raises an underrun indication.

Top module: `fifo_dma_req`

## Requirements
- R1: After reset the fill count is 0, and both request lines and both flags are low.
- R2: Words leave the buffer in the order they were accepted. The storage index wraps modulo 32, so a run of writes that passes index 31 keeps its order.
- R3: A push offered while the buffer holds 32 words is dropped. The fill count and the stored words do not change. This holds even when a pop occurs in the same cycle.
- R4: A host read of an empty buffer asserts `underrun` in the same cycle. It returns the word at the current head position and leaves the fill count at 0.
- R5: In receive direction (`dir_rx`=1), when the fill count is above the high level, `rx_req` is raised if receive DMA is enabled; otherwise `rx_flag` is raised. Loading the enable as 1 clears `rx_flag` from the next cycle on.
- R6: In transmit direction (`dir_rx`=0), when the fill count is below the low level, `tx_req` is raised if transmit DMA is enabled; otherwise `tx_flag` is raised. Loading the enable as 1 clears `tx_flag` from the next cycle on.
- R7: When a watermark condition does not hold, its request line and its flag are both low. In particular, the receive pair is low in transmit direction, and the transmit pair is low in receive direction.
- R8: While `xfer_active` is 0 and the buffer is empty, all four indications are low. A buffer that is not empty is evaluated even when no transfer is active.
- R9: Data is routed by direction. In receive direction, `card_push` fills the buffer and `host_rd` drains it, and `host_wr` is ignored. In transmit direction, `host_wr` fills the buffer and `card_pop` drains it, and `card_push` is ignored.
- R10: Reset sets the high level to 31, the low level to 0, and both DMA enables to 0. As a result, only a completely full buffer raises `rx_flag`, and `tx_flag` never rises.
- R11: The indications are computed from the registered fill count with no further register stage. A request drops in the first cycle after the edge that accepts the pop ending its condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe (pushes in transmit direction) |
| host_wdata | input | 16 | Host write word |
| host_rd | input | 1 | Host read strobe (pops in receive direction) |
| card_push | input | 1 | Card-side push strobe (receive direction) |
| card_wdata | input | 16 | Card-side push word |
| card_pop | input | 1 | Card-side pop strobe (transmit direction) |
| head_word | output | 16 | Word at the head position, seen by both readers |
| dir_rx | input | 1 | 1 = receive direction, 0 = transmit direction |
| xfer_active | input | 1 | A transfer is in progress |
| cfg_wr | input | 1 | Loads levels and DMA enables |
| cfg_hi_lvl | input | 5 | High (receive) watermark |
| cfg_lo_lvl | input | 5 | Low (transmit) watermark |
| cfg_rx_dma | input | 1 | Receive DMA enable |
| cfg_tx_dma | input | 1 | Transmit DMA enable |
| rx_req | output | 1 | Receive DMA request |
| tx_req | output | 1 | Transmit DMA request |
| rx_flag | output | 1 | Polled receive watermark flag |
| tx_flag | output | 1 | Polled transmit watermark flag |
| fill | output | 6 | Number of stored words, 0 to 32 |
| underrun | output | 1 | Host read of an empty buffer in this cycle |

## Verification
The assertions check the following on every cycle:
- the fill count stays within 0 to 32 and moves by at most one per cycle;
- a full buffer refuses a push, and an empty read holds the count at zero;
- a request and its flag are never high together;
- the pair belonging to the other direction stays low;
- an idle, empty buffer shows no indication.

Other properties depend on data values and configuration history, so only the directed scenarios can show them:
- word order across the index wrap;
- the value returned by an underrun read;
- the reset watermark values;
- the choice between request and flag after each reconfiguration;
- the one-cycle timing of a request falling after a pop.

// File: rtl/fifo_dma_pkg.sv
// Package: shared types for the FIFO DMA requester.
// Assumes nothing beyond the data-path direction being a single bit.
package fifo_dma_pkg;

    // Transfer direction as decoded from the direction input.
    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } xfer_dir_e;

    // One watermark indication: either a DMA request or a polled flag.
    typedef struct packed {
        logic req;
        logic flag;
    } wm_ind_t;

endpackage

// File: rtl/fdr_store.sv
// Module: circular word store with a head pointer and a fill count.
// Accepts at most one push and one pop per cycle. A push into a full store
// is dropped even when a pop happens in the same cycle. A pop from an empty
// store is ignored. DEPTH is assumed to be a power of two.
module fdr_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [CNT_W-1:0] count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [IDX_W-1:0] head_q;
    logic [CNT_W-1:0] count_q;
    logic [IDX_W-1:0] tail_idx;
    logic             push_ok;
    logic             pop_ok;

    // Qualify the strobes against full and empty, and locate the tail.
    always_comb begin
        push_ok  = push && (count_q != CNT_W'(DEPTH));
        pop_ok   = pop && (count_q != '0);
        tail_idx = head_q + IDX_W'(count_q);
    end

    // Write an accepted word at the tail slot.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[tail_idx] <= push_data;
        end
    end

    // Advance the head and track the number of stored words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            if (pop_ok) begin
                head_q <= head_q + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_data = mem[head_q];
    assign count     = count_q;

endmodule

// File: rtl/fdr_cfg.sv
// Module: holds the two watermark levels and the two DMA enables.
// All four values are loaded together on a single strobe. Reset leaves the
// high level at its maximum, the low level at zero and DMA disabled.
module fdr_cfg #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LVL_W-1:0] hi_in,
    input  logic [LVL_W-1:0] lo_in,
    input  logic             rx_en_in,
    input  logic             tx_en_in,
    output logic [LVL_W-1:0] hi_lvl,
    output logic [LVL_W-1:0] lo_lvl,
    output logic             rx_en,
    output logic             tx_en
);

    // Capture the configuration, or restore the defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_lvl <= '1;
            lo_lvl <= '0;
            rx_en  <= 1'b0;
            tx_en  <= 1'b0;
        end else if (load) begin
            hi_lvl <= hi_in;
            lo_lvl <= lo_in;
            rx_en  <= rx_en_in;
            tx_en  <= tx_en_in;
        end
    end

endmodule

// File: rtl/fdr_thresh.sv
// Module: combinational watermark evaluation.
// Turns the registered fill count into request and flag outputs. Each
// direction's condition drives its DMA request when DMA is enabled for that
// direction, and its polled flag otherwise. Nothing is reported while the
// store is idle (no transfer and no data).
module fdr_thresh
    import fifo_dma_pkg::*;
#(
    parameter int LVL_W = 5,
    localparam int CNT_W = LVL_W + 1
) (
    input  logic [CNT_W-1:0] count,
    input  xfer_dir_e        dir,
    input  logic             active,
    input  logic [LVL_W-1:0] hi_lvl,
    input  logic [LVL_W-1:0] lo_lvl,
    input  logic             rx_en,
    input  logic             tx_en,
    output wm_ind_t          rx_ind,
    output wm_ind_t          tx_ind
);

    logic live;
    logic rx_cond;
    logic tx_cond;

    // Decide whether each watermark condition currently holds.
    always_comb begin
        live    = active || (count != '0);
        rx_cond = live && (dir == DIR_RX) && (count > CNT_W'(hi_lvl));
        tx_cond = live && (dir == DIR_TX) && (count < CNT_W'(lo_lvl));
    end

    // Send each condition to its request line or to its polled flag.
    always_comb begin
        rx_ind.req  = rx_cond && rx_en;
        rx_ind.flag = rx_cond && !rx_en;
        tx_ind.req  = tx_cond && tx_en;
        tx_ind.flag = tx_cond && !tx_en;
    end

endmodule

// File: rtl/fifo_dma_req.sv
// Module: top level of the threshold-driven FIFO DMA requester.
// Routes host and card strobes into the store according to direction, holds
// the configuration, and raises watermark requests or flags. Assumes the
// strobes are single-cycle qualified pulses in the clock domain.
module fifo_dma_req
    import fifo_dma_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             host_rd,
    input  logic             card_push,
    input  logic [WIDTH-1:0] card_wdata,
    input  logic             card_pop,
    output logic [WIDTH-1:0] head_word,
    input  logic             dir_rx,
    input  logic             xfer_active,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_hi_lvl,
    input  logic [IDX_W-1:0] cfg_lo_lvl,
    input  logic             cfg_rx_dma,
    input  logic             cfg_tx_dma,
    output logic             rx_req,
    output logic             tx_req,
    output logic             rx_flag,
    output logic             tx_flag,
    output logic [CNT_W-1:0] fill,
    output logic             underrun
);

    xfer_dir_e        dir;
    logic             push;
    logic             pop;
    logic [WIDTH-1:0] push_data;
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] hi_lvl;
    logic [IDX_W-1:0] lo_lvl;
    logic             rx_en;
    logic             tx_en;
    wm_ind_t          rx_ind;
    wm_ind_t          tx_ind;

    // Choose the pushing and popping side from the transfer direction.
    always_comb begin
        dir = xfer_dir_e'(dir_rx);
        if (dir == DIR_RX) begin
            push      = card_push;
            push_data = card_wdata;
            pop       = host_rd;
        end else begin
            push      = host_wr;
            push_data = host_wdata;
            pop       = card_pop;
        end
    end

    fdr_store #(
        .DEPTH(DEPTH),
        .WIDTH(WIDTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head_data (head_word),
        .count     (count)
    );

    fdr_cfg #(
        .LVL_W(IDX_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .hi_in    (cfg_hi_lvl),
        .lo_in    (cfg_lo_lvl),
        .rx_en_in (cfg_rx_dma),
        .tx_en_in (cfg_tx_dma),
        .hi_lvl   (hi_lvl),
        .lo_lvl   (lo_lvl),
        .rx_en    (rx_en),
        .tx_en    (tx_en)
    );

    fdr_thresh #(
        .LVL_W(IDX_W)
    ) u_thresh (
        .count  (count),
        .dir    (dir),
        .active (xfer_active),
        .hi_lvl (hi_lvl),
        .lo_lvl (lo_lvl),
        .rx_en  (rx_en),
        .tx_en  (tx_en),
        .rx_ind (rx_ind),
        .tx_ind (tx_ind)
    );

    // Drive the outputs from the store and the evaluator.
    always_comb begin
        fill     = count;
        rx_req   = rx_ind.req;
        rx_flag  = rx_ind.flag;
        tx_req   = tx_ind.req;
        tx_flag  = tx_ind.flag;
        underrun = host_rd && (count == '0);
    end

endmodule

// File: rtl/fifo_dma_req_chk.sv
// Checker: port-level properties of the FIFO DMA requester, bound to the top.
module fifo_dma_req_chk #(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic             card_push,
    input logic             card_pop,
    input logic             dir_rx,
    input logic             xfer_active,
    input logic             rx_req,
    input logic             tx_req,
    input logic             rx_flag,
    input logic             tx_flag,
    input logic [CNT_W-1:0] fill,
    input logic             underrun
);

    // R1: the count never exceeds the depth.
    a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R2: the count moves by at most one per cycle.
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fill == $past(fill)) || (fill == $past(fill) + 1'b1)
                         || (fill + 1'b1 == $past(fill)));

    // R3: a full buffer in transmit direction refuses a host write.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH)) && host_wr && !dir_rx && !card_pop
        |=> fill == CNT_W'(DEPTH));

    // R4: underrun only on an empty buffer, and the count stays zero.
    a_r4_underrun_empty: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> fill == '0);
    a_r4_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx && host_rd && !card_push && (fill == '0) |=> fill == '0);

    // R5, R6: request and flag of one direction are exclusive.
    a_r5_rx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_req && rx_flag));
    a_r6_tx_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && tx_flag));

    // R7: the other direction's pair stays low.
    a_r7_rx_dir_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx |-> !tx_req && !tx_flag);
    a_r7_tx_dir_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_rx |-> !rx_req && !rx_flag);

    // R8: idle and empty means no indication at all.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active && (fill == '0) |-> !rx_req && !rx_flag && !tx_req && !tx_flag);

    // R9: host writes in receive direction leave the count alone.
    a_r9_rx_host_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        dir_rx && host_wr && !card_push && !host_rd |=> fill == $past(fill));

endmodule

bind fifo_dma_req fifo_dma_req_chk #(
    .DEPTH(DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .card_push   (card_push),
    .card_pop    (card_pop),
    .dir_rx      (dir_rx),
    .xfer_active (xfer_active),
    .rx_req      (rx_req),
    .tx_req      (tx_req),
    .rx_flag     (rx_flag),
    .tx_flag     (tx_flag),
    .fill        (fill),
    .underrun    (underrun)
);

// File: tb/sim_fifo_dma_req.sv
// Directed bench for the FIFO DMA requester. Each task drives one scenario
// and checks its own results.
module sim_fifo_dma_req;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        host_rd = 1'b0;
    logic        card_push = 1'b0;
    logic [15:0] card_wdata = '0;
    logic        card_pop = 1'b0;
    logic [15:0] head_word;
    logic        dir_rx = 1'b0;
    logic        xfer_active = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_hi_lvl = '0;
    logic [4:0]  cfg_lo_lvl = '0;
    logic        cfg_rx_dma = 1'b0;
    logic        cfg_tx_dma = 1'b0;
    logic        rx_req, tx_req, rx_flag, tx_flag, underrun;
    logic [5:0]  fill;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    fifo_dma_req u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
        .head_word(head_word), .dir_rx(dir_rx), .xfer_active(xfer_active),
        .cfg_wr(cfg_wr), .cfg_hi_lvl(cfg_hi_lvl), .cfg_lo_lvl(cfg_lo_lvl),
        .cfg_rx_dma(cfg_rx_dma), .cfg_tx_dma(cfg_tx_dma),
        .rx_req(rx_req), .tx_req(tx_req), .rx_flag(rx_flag), .tx_flag(tx_flag),
        .fill(fill), .underrun(underrun)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int hi, input int lo, input bit rxe, input bit txe);
        cfg_hi_lvl = 5'(hi);
        cfg_lo_lvl = 5'(lo);
        cfg_rx_dma = rxe;
        cfg_tx_dma = txe;
        cfg_wr     = 1'b1;
        tick();
        cfg_wr     = 1'b0;
    endtask

    task automatic host_write(input logic [15:0] v);
        host_wr = 1'b1; host_wdata = v;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic card_write(input logic [15:0] v);
        card_push = 1'b1; card_wdata = v;
        tick();
        card_push = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 fill", fill, 0);
        chk("R1 indications", {rx_req, tx_req, rx_flag, tx_flag}, 0);
    endtask

    task automatic t_defaults_full_underrun();
        dir_rx = 1'b0; xfer_active = 1'b1;
        #1;
        chk("R10 tx_flag with low level 0", tx_flag, 0);
        for (int i = 0; i < 32; i++) host_write(16'h1000 + 16'(i));
        chk("R3 fill at full", fill, 32);
        host_write(16'hDEAD);
        chk("R3 fill after dropped write", fill, 32);
        dir_rx = 1'b1;
        #1;
        chk("R10 rx_flag at 32 with high level 31", rx_flag, 1);
        chk("R10 rx_req off by default", rx_req, 0);
        for (int i = 0; i < 32; i++) begin
            chk("R2 R3 order at full", head_word, 16'h1000 + 16'(i));
            host_rd = 1'b1;
            tick();
            host_rd = 1'b0;
            if (i == 0) chk("R7 rx_flag falls below level", rx_flag, 0);
        end
        chk("R9 host drain empties", fill, 0);
        host_rd = 1'b1;
        #1;
        chk("R4 underrun", underrun, 1);
        chk("R4 head word returned", head_word, 16'h1000);
        tick();
        host_rd = 1'b0;
        chk("R4 fill stays 0", fill, 0);
    endtask

    task automatic t_rx_dma();
        set_cfg(3, 0, 1'b1, 1'b0);
        dir_rx = 1'b1; xfer_active = 1'b1;
        for (int i = 0; i < 3; i++) card_write(16'h2000 + 16'(i));
        chk("R5 no request at level", rx_req, 0);
        card_write(16'h2003);
        chk("R5 rx_req above level", rx_req, 1);
        chk("R5 no flag with dma", rx_flag, 0);
        host_write(16'hBEEF);
        chk("R9 host write ignored in rx", fill, 4);
        set_cfg(3, 0, 1'b0, 1'b0);
        chk("R5 flag without dma", rx_flag, 1);
        chk("R5 no request without dma", rx_req, 0);
        set_cfg(3, 0, 1'b1, 1'b0);
        chk("R5 enable clears flag", rx_flag, 0);
        chk("R5 request back", rx_req, 1);
        chk("R2 rx head", head_word, 16'h2000);
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
        chk("R11 request drops after pop", rx_req, 0);
        for (int i = 1; i < 4; i++) begin
            chk("R2 rx order", head_word, 16'h2000 + 16'(i));
            host_rd = 1'b1;
            tick();
            host_rd = 1'b0;
        end
        chk("R9 rx drained", fill, 0);
    endtask

    task automatic t_tx_dma();
        dir_rx = 1'b0; xfer_active = 1'b1;
        set_cfg(31, 2, 1'b0, 1'b0);
        chk("R6 tx_flag below level", tx_flag, 1);
        set_cfg(31, 2, 1'b0, 1'b1);
        chk("R6 tx_req with dma", tx_req, 1);
        chk("R6 enable clears flag", tx_flag, 0);
        host_write(16'h3000);
        chk("R6 still below level", tx_req, 1);
        host_write(16'h3001);
        chk("R7 tx_req off at level", tx_req, 0);
        chk("R7 tx_flag off at level", tx_flag, 0);
        card_write(16'hCAFE);
        chk("R9 card push ignored in tx", fill, 2);
        chk("R2 tx head", head_word, 16'h3000);
        card_pop = 1'b1;
        tick();
        card_pop = 1'b0;
        chk("R11 tx_req rises after pop", tx_req, 1);
        chk("R2 tx second", head_word, 16'h3001);
        card_pop = 1'b1;
        tick();
        card_pop = 1'b0;
        chk("R9 tx drained", fill, 0);
    endtask

    task automatic t_wrap();
        dir_rx = 1'b0; xfer_active = 1'b1;
        for (int i = 0; i < 30; i++) host_write(16'h4000 + 16'(i));
        chk("R2 wrap fill", fill, 30);
        for (int i = 0; i < 30; i++) begin
            chk("R2 wrap order", head_word, 16'h4000 + 16'(i));
            card_pop = 1'b1;
            tick();
            card_pop = 1'b0;
        end
        chk("R2 wrap drained", fill, 0);
    endtask

    task automatic t_idle();
        dir_rx = 1'b0; xfer_active = 1'b0;
        #1;
        chk("R8 idle no request", tx_req, 0);
        chk("R8 idle no flag", tx_flag, 0);
        host_write(16'h5000);
        chk("R8 nonempty evaluated", tx_req, 1);
        card_pop = 1'b1;
        tick();
        card_pop = 1'b0;
        chk("R8 idle again quiet", tx_req, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_defaults_full_underrun();
        t_rx_dma();
        t_tx_dma();
        t_wrap();
        t_idle();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule